// File: doc/BRIEF.md
# Quad-Phase Oversampling Bit Recovery

This block turns an asynchronous serial line into a stream of recovered bits in the local clock domain. Each local clock period it receives four samples of the line. They are taken at 0, 1/4, 1/2 and 3/4 of the period and are already aligned to the main clock. Every sample lane passes through its own synchroniser chain.

The block finds transitions by comparing samples one quarter apart. One of these pairs crosses the clock boundary: the last sample of the previous period against the first sample of this one. From the transitions it picks the sampling phase farthest from the latest transition.

The transmit oscillator and the local oscillator never run at exactly the same rate. Because of this, the chosen phase slowly walks around the period. When the phase wraps across the period boundary, the block delivers no bit in that cycle or two bits in that cycle, depending on the direction of the wrap. A valid mask marks which output bits carry data.

The output has no ready signal and accepts no back-pressure, because the line cannot be stalled. The two mask bits act as the stream's valid qualifiers. The consumer must take every flagged bit in the cycle it appears, oldest first on bit 0. A mask value of 2'b10 is never produced.

Top module: `qor_recover`

## Requirements
- R1: While `rst` is high, `bit_vld_o` and `bit_o` are both 2'b00, and the internal phase returns to 0 (the quarter at index 0).
- R2: The sample word present on `samp_i` at rising edge t determines the outputs visible after edge t+SYNC_STAGES. SYNC_STAGES is 2 by default.
- R3: A transition in quarter k is recorded when sample k differs from the sample before it. For k=0 that earlier sample is sample 3 of the previous word; for k=1..3 it is sample k-1 of the same word. `samp_i[k]` is the sample taken k quarters into the period.
- R4: When exactly one quarter k shows a transition, the phase becomes (k+2) mod 4.
- R5: A word with no transition leaves the phase unchanged.
- R6: A word with two or more transitions leaves the phase unchanged.
- R7: When the phase moves from 3 to 0, that cycle's output has `bit_vld_o`=2'b00 and `bit_o`=2'b00.
- R8: When the phase moves from 0 to 3, that cycle's output has `bit_vld_o`=2'b11, `bit_o[0]`=sample 0 and `bit_o[1]`=sample 3 of the word.
- R9: In every other cycle, `bit_vld_o`=2'b01, `bit_o[0]` is the sample at the new phase, and `bit_o[1]`=0.
- R10: `bit_vld_o` never equals 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_i | input | 4 | Line samples; bit k taken k quarter periods into the clock period |
| bit_o | output | 2 | Recovered bits; bit 0 is the older |
| bit_vld_o | output | 2 | Valid mask: 00 none, 01 one bit, 11 two bits |

## Verification
Two functions can fall in the same cycle: a phase wrap across the period boundary and the choice of the number of bits to emit. Which of them happens depends on which quarter saw the transition. The bench provokes wraps with a line whose bit periods sometimes run five quarters, which forces forward wraps and dropped cycles. It also uses a line whose bit periods sometimes run three quarters, which forces backward wraps and double-bit cycles. Further runs add jitter and glitches, so that multi-transition words land next to wraps. Every output cycle is judged against a bench model that applies the phase rules. Directed words pin down a dropped cycle, a double-bit cycle, a boundary-crossing transition and an ambiguous word.

// File: rtl/qor_pkg.sv
package qor_pkg;
  localparam int unsigned NPH = 4;
  typedef logic [1:0] phase_t;
  localparam phase_t PH_FIRST = 2'd0;
  localparam phase_t PH_LAST  = 2'd3;
  localparam phase_t PH_HALF  = 2'd2;
endpackage

// File: rtl/qor_sync.sv
module qor_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LANES  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);
  logic [LANES-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qor_edges.sv
module qor_edges #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] smp,
  output logic [LANES-1:0] edges
);
  logic tail_q;

  // last sample of the previous word, for the boundary-crossing pair
  always_ff @(posedge clk) begin
    if (rst) tail_q <= 1'b0;
    else     tail_q <= smp[LANES-1];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_quarter
    if (k == 0) begin : g_wrap
      assign edges[k] = tail_q ^ smp[0];
    end else begin : g_inner
      assign edges[k] = smp[k-1] ^ smp[k];
    end
  end
endmodule

// File: rtl/qor_pick.sv
module qor_pick
  import qor_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] smp,
  input  logic [3:0] edges,
  output logic [1:0] bit_o,
  output logic [1:0] vld_o
);
  phase_t     phase_q, phase_n;
  phase_t     hit_idx;
  int unsigned hit_cnt;
  logic [1:0] bit_n, vld_n;
  logic       slip_back, slip_fwd;

  always_comb begin
    hit_cnt = 0;
    hit_idx = PH_FIRST;
    for (int k = 0; k < NPH; k++) begin
      if (edges[k]) begin
        hit_cnt = hit_cnt + 1;
        hit_idx = phase_t'(k);
      end
    end
    phase_n = phase_q;
    if (hit_cnt == 1) phase_n = hit_idx + PH_HALF;
    slip_back = (phase_q == PH_LAST)  && (phase_n == PH_FIRST);
    slip_fwd  = (phase_q == PH_FIRST) && (phase_n == PH_LAST);
    if (slip_back) begin
      vld_n = 2'b00;
      bit_n = 2'b00;
    end else if (slip_fwd) begin
      vld_n = 2'b11;
      bit_n = {smp[PH_LAST], smp[PH_FIRST]};
    end else begin
      vld_n = 2'b01;
      bit_n = {1'b0, smp[phase_n]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FIRST;
      vld_o   <= 2'b00;
      bit_o   <= 2'b00;
    end else begin
      phase_q <= phase_n;
      vld_o   <= vld_n;
      bit_o   <= bit_n;
    end
  end

  p_single_move_r4: assert property (@(posedge clk) disable iff (rst)
    (edges == 4'b0001) |=> (phase_q == PH_HALF));
  p_quiet_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (edges == 4'b0000) |=> $stable(phase_q));
  p_multi_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ($countones(edges) > 1) |=> $stable(phase_q));
  p_wrap_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LAST && edges == 4'b0100) |=> (vld_o == 2'b00));
  p_wrap_double_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FIRST && edges == 4'b0010) |=> (vld_o == 2'b11));
  p_mask_legal_r10: assert property (@(posedge clk) disable iff (rst)
    vld_o != 2'b10);
endmodule

// File: rtl/qor_recover.sv
module qor_recover
  import qor_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] samp_i,
  output logic [1:0] bit_o,
  output logic [1:0] bit_vld_o
);
  localparam int unsigned LANES = NPH;

  logic [LANES-1:0] smp_s;
  logic [LANES-1:0] edges;

  qor_sync #(.STAGES(SYNC_STAGES), .LANES(LANES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (samp_i),
    .q   (smp_s)
  );

  qor_edges #(.LANES(LANES)) u_edges (
    .clk   (clk),
    .rst   (rst),
    .smp   (smp_s),
    .edges (edges)
  );

  qor_pick u_pick (
    .clk   (clk),
    .rst   (rst),
    .smp   (smp_s),
    .edges (edges),
    .bit_o (bit_o),
    .vld_o (bit_vld_o)
  );
endmodule

// File: tb/test_qor_recover.sv
module test_qor_recover;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] samp = 4'b0000;
  logic [1:0] bit_o, bit_vld_o;

  always #10 clk = ~clk;

  qor_recover i_qor_recover (
    .clk       (clk),
    .rst       (rst),
    .samp_i    (samp),
    .bit_o     (bit_o),
    .bit_vld_o (bit_vld_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] m_phase = 2'd0;
  logic       m_tail = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  int cnt_drop = 0;
  int cnt_dbl  = 0;
  logic line_bit = 1'b0;
  int   line_left = 0;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // bench model of the phase rules (R3..R9)
  task automatic model_push(input logic [3:0] w);
    logic [3:0] e;
    int n;
    logic [1:0] idx, np, v, b;
    string t;
    e = {w[2] ^ w[3], w[1] ^ w[2], w[0] ^ w[1], m_tail ^ w[0]};
    n = 0; idx = 0;
    for (int k = 0; k < 4; k++) if (e[k]) begin n++; idx = 2'(k); end
    np = m_phase;
    if (n == 1) np = idx + 2'd2;
    if (n == 0) t = "R5"; else if (n == 1) t = "R3 R4"; else t = "R6";
    if (m_phase == 2'd3 && np == 2'd0) begin
      v = 2'b00; b = 2'b00; t = {t, " R7"};
    end else if (m_phase == 2'd0 && np == 2'd3) begin
      v = 2'b11; b = {w[3], w[0]}; t = {t, " R8"};
    end else begin
      v = 2'b01; b = {1'b0, w[np]}; t = {t, " R9"};
    end
    m_tail = w[3];
    m_phase = np;
    exp_q.push_back({v, b});
    tag_q.push_back(t);
  endtask

  task automatic cycle(input logic [3:0] w);
    logic [3:0] ex;
    string t;
    @(negedge clk);
    ex = exp_q.pop_front();
    t  = tag_q.pop_front();
    checks++;
    if (bit_vld_o !== ex[3:2] || bit_o !== ex[1:0]) begin
      errors++;
      $display("FAIL %s R2: got vld=%b bits=%b expected vld=%b bits=%b",
               t, bit_vld_o, bit_o, ex[3:2], ex[1:0]);
    end
    checks++;
    if (bit_vld_o === 2'b10) begin
      errors++;
      $display("FAIL R10: got vld=%b expected not 10", bit_vld_o);
    end
    if (bit_vld_o === 2'b00) cnt_drop++;
    if (bit_vld_o === 2'b11) cnt_dbl++;
    samp = w;
    model_push(w);
  endtask

  function automatic int bit_len(input int mode);
    case (mode)
      1: return (($urandom % 8) == 0) ? 5 : 4;
      2: return (($urandom % 8) == 0) ? 3 : 4;
      3: return 3 + int'($urandom % 3);
      default: return 4;
    endcase
  endfunction

  task automatic send_line(input int nwords, input int mode, input bit glitch);
    logic [3:0] w;
    for (int i = 0; i < nwords; i++) begin
      for (int q = 0; q < 4; q++) begin
        if (line_left == 0) begin
          line_bit  = 1'($urandom % 2);
          line_left = bit_len(mode);
        end
        w[q] = line_bit;
        line_left--;
        if (glitch && (($urandom % 16) == 0)) w[q] = ~w[q];
      end
      cycle(w);
    end
  endtask

  task automatic expect_count(input string req, input int got, input bit want_nonzero);
    checks++;
    if (want_nonzero ? (got == 0) : (got != 0)) begin
      errors++;
      $display("FAIL %s: count got %0d expected %s", req, got, want_nonzero ? ">0" : "0");
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) cycle(samp);
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (bit_vld_o !== 2'b00 || bit_o !== 2'b00) begin
      errors++;
      $display("FAIL R1: got vld=%b bits=%b expected vld=00 bits=00", bit_vld_o, bit_o);
    end
    model_push(4'b0000);
    model_push(4'b0000);
    model_push(4'b0000);
    rst = 1'b0;

    // directed corner cases
    cycle(4'b0000); cycle(4'b0000);      // R5 quiet line
    cycle(4'b1110);                      // R8 single edge in quarter 1, phase 0 -> 3
    cycle(4'b1111);                      // R5 hold at 3
    cycle(4'b1100);                      // R6 two edges, hold
    cycle(4'b0011);                      // R7 edge in quarter 2, phase 3 -> 0
    cycle(4'b1111);
    cycle(4'b0000);                      // R3 boundary-crossing edge -> phase 2
    cycle(4'b0101);                      // R6 many edges
    flush();
    expect_count("R7 directed drop", cnt_drop, 1'b1);
    expect_count("R8 directed double", cnt_dbl, 1'b1);

    // slow transmitter: drops only
    send_line(20, 0, 1'b0);
    cnt_drop = 0; cnt_dbl = 0;
    send_line(800, 1, 1'b0);
    flush();
    expect_count("R7 slow line drops", cnt_drop, 1'b1);
    expect_count("R8 slow line never doubles", cnt_dbl, 1'b0);

    // fast transmitter: doubles only
    send_line(20, 0, 1'b0);
    cnt_drop = 0; cnt_dbl = 0;
    send_line(800, 2, 1'b0);
    flush();
    expect_count("R8 fast line doubles", cnt_dbl, 1'b1);
    expect_count("R7 fast line never drops", cnt_drop, 1'b0);

    // jitter and glitches, both slips possible
    send_line(1000, 3, 1'b0);
    send_line(800, 0, 1'b1);
    send_line(800, 3, 1'b1);
    flush();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end
endmodule